// File: doc/BRIEF.md
# Byte-Serial Counter Host Register Interface

This block sits between an 8-bit host bus and one 24-bit up/down counter channel. The host reaches it through two byte-wide ports, chosen by `bus_sel_ctl`. The data port moves 24-bit quantities one byte at a time:

- Writes fill a preset register.
- Reads drain a snapshot latch.

Both directions share one byte pointer. The pointer advances after every data-port access and returns to byte 0 after the third.

The control port takes command bytes. The top three bits of a command byte choose a destination:

- One of three configuration registers: count mode, I/O control or index control.
- The action decoder, whose low five bits hold three independent fields: a pointer reset, a clear operation and a transfer operation.

A control-port read returns the counter's status flags.

The counting logic is outside this block. It receives the preset value, the configuration fields, the filter prescaler value and one-cycle pulses for the following actions:

- load from preset
- clear the count
- clear the toggle and sign flags
- clear the noise error

It returns its live count and four flag bits.

Top module: `cnt_host_regs`

## Requirements
- R1: After a synchronous reset, the byte pointer, preset, snapshot latch, prescaler and all configuration fields are zero, and no action pulse is high.
- R2: A control write whose bits 7:5 equal 001 loads `count_mode` from bits 2:1 and `quad_mode` from bits 4:3. The new values are visible one cycle after the write.
- R3: A control write whose bits 7:5 equal 010 loads `ab_enable` from bit 0, `index_load_n` (active low) from bit 1 and `irq_src` from bits 4:3.
- R4: A control write whose bits 7:5 equal 011 loads `index_sync` from bit 0 and `index_positive` from bit 1. A value of 1 in bit 1 means positive polarity.
- R5: A control write whose bit 7 is 1 changes no register, no output and no pointer, and raises no pulse.
- R6: Data-port writes fill the preset least significant byte first, one byte per access. The pointer wraps to byte 0 after the third byte, and the preset changes only on data-port writes.
- R7: Data-port reads return the snapshot latch least significant byte first, with the same pointer and the same wrap. The latch captures `cnt_value` only on an action byte whose bits 4:3 are 10, so later count changes do not disturb a read in progress.
- R8: An action byte (bits 7:5 = 000) with bit 0 set returns the pointer to byte 0. This reset can be combined with any transfer code in the same byte.
- R9: An action byte raises the following pulses in the cycle after the write:
  - bits 2:1 = 01 raises `clear_count`
  - bits 2:1 = 10 raises `clear_flags`
  - bits 2:1 = 11 raises `clear_error`
  - bits 4:3 = 01 raises `load_preset`
  Each pulse lasts exactly one cycle.
- R10: An action byte with bits 4:3 = 11 copies the preset's low byte into `prescaler`. Nothing else changes `prescaler`.
- R11: While `bus_sel_ctl` is high, `bus_rdata` returns the flag byte: bit 0 borrow toggle, bit 1 carry toggle, bit 4 noise error, bit 5 up/down, all other bits zero. A control-port read leaves the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one byte per cycle |
| bus_rd | input | 1 | Host read strobe, one byte per cycle |
| bus_sel_ctl | input | 1 | 1 selects the control/flag port, 0 the data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte: flag byte or the latch byte at the pointer |
| cnt_value | input | 24 | Live count from the counting logic |
| flag_borrow | input | 1 | Borrow toggle flag |
| flag_carry | input | 1 | Carry toggle flag |
| flag_noise | input | 1 | Noise error flag |
| flag_up | input | 1 | Direction flag, 1 for up |
| preset_val | output | 24 | Preset register |
| load_preset | output | 1 | Pulse: load preset into the counter |
| clear_count | output | 1 | Pulse: clear the counter |
| clear_flags | output | 1 | Pulse: clear borrow, carry, compare and sign flags |
| clear_error | output | 1 | Pulse: clear the noise error flag |
| count_mode | output | 2 | Count mode field |
| quad_mode | output | 2 | Quadrature mode field |
| ab_enable | output | 1 | A/B input enable |
| index_load_n | output | 1 | Active-low enable for index-triggered preset load |
| irq_src | output | 2 | Flag/interrupt source select |
| index_sync | output | 1 | Synchronous index operation |
| index_positive | output | 1 | Index polarity, 1 for positive |
| prescaler | output | 8 | Filter clock prescaler value |

## Verification
The assertions check the following on every cycle:

- The pointer never leaves its three-byte range, and it wraps after the last byte.
- The preset, snapshot latch and prescaler hold still unless their own write or transfer occurred.
- A load pulse always follows a matching action byte.
- A control byte whose bit 7 is 1 changes nothing.

Only the bench's scenarios can show that bytes land in the right lanes in least-significant-first order. They also show that the latch keeps a coherent snapshot while the count moves, and that each of the 256 control bytes sets exactly the fields and pulses it encodes. The bench tracks the pointer across interleaved commands, reads and writes to demonstrate this.

// File: rtl/cnt_host_pkg.sv
package cnt_host_pkg;

    typedef enum logic [2:0] {
        SEL_ACTION = 3'b000,
        SEL_MODE   = 3'b001,
        SEL_IOCTL  = 3'b010,
        SEL_INDEX  = 3'b011
    } tgt_sel_e;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'b00,
        CLR_COUNT = 2'b01,
        CLR_FLAGS = 2'b10,
        CLR_ERROR = 2'b11
    } clr_op_e;

    typedef enum logic [1:0] {
        XFR_NONE     = 2'b00,
        XFR_TO_COUNT = 2'b01,
        XFR_TO_LATCH = 2'b10,
        XFR_TO_PSC   = 2'b11
    } xfr_op_e;

    typedef struct packed {
        xfr_op_e xfr;
        clr_op_e clr;
        logic    ptr_rst;
    } action_t;

    typedef struct packed {
        logic [1:0] quad_mode;
        logic [1:0] count_mode;
    } mode_cfg_t;

    typedef struct packed {
        logic [1:0] irq_src;
        logic       index_load_n;
        logic       ab_en;
    } io_cfg_t;

    typedef struct packed {
        logic index_pos;
        logic index_sync;
    } idx_cfg_t;

    typedef struct packed {
        logic up;
        logic noise;
        logic carry;
        logic borrow;
    } flag_in_t;

    function automatic action_t decode_action(input logic [4:0] f);
        action_t a;
        a.ptr_rst = f[0];
        a.clr     = clr_op_e'(f[2:1]);
        a.xfr     = xfr_op_e'(f[4:3]);
        return a;
    endfunction

    function automatic logic [7:0] pack_flags(input flag_in_t f);
        return {2'b00, f.up, f.noise, 2'b00, f.carry, f.borrow};
    endfunction

endpackage

// File: rtl/cnt_byte_ptr.sv
module cnt_byte_ptr #(
    parameter int NUM_BYTES = 3,
    parameter int PTR_W     = $clog2(NUM_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             clear,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BYTES - 1);

    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            ptr_q <= '0;
        else if (advance)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    assign ptr = ptr_q;

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST);

    // R6
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear && ptr_q == LAST) |=> ptr_q == '0);

endmodule

// File: rtl/cnt_preset_latch.sv
module cnt_preset_latch #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int PTR_W     = $clog2(NUM_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [PTR_W-1:0]            ptr,
    input  logic                        data_wr,
    input  logic [BYTE_W-1:0]           wdata,
    input  logic                        latch_xfer,
    input  logic [BYTE_W*NUM_BYTES-1:0] cnt_value,
    output logic [BYTE_W*NUM_BYTES-1:0] preset_q,
    output logic [BYTE_W-1:0]           rd_byte
);
    localparam int WORD_W = BYTE_W * NUM_BYTES;

    logic [WORD_W-1:0] latch_q;

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (data_wr && ptr == PTR_W'(k))
                lane_q <= wdata;
        end
        assign preset_q[k*BYTE_W +: BYTE_W] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '0;
        else if (latch_xfer)
            latch_q <= cnt_value;
    end

    assign rd_byte = latch_q[BYTE_W*ptr +: BYTE_W];

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !latch_xfer |=> $stable(latch_q));

    // R6
    preset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !data_wr |=> $stable(preset_q));

endmodule

// File: rtl/cnt_cmd_decode.sv
module cnt_cmd_decode
    import cnt_host_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_wr,
    input  logic [7:0] wdata,
    output mode_cfg_t mode_q,
    output io_cfg_t   io_q,
    output idx_cfg_t  idx_q,
    output logic      ptr_clr,
    output logic      latch_xfer,
    output logic      psc_load,
    output logic      load_preset,
    output logic      clear_count,
    output logic      clear_flags,
    output logic      clear_error
);
    tgt_sel_e sel;
    action_t  act;
    logic     act_wr;

    assign sel    = tgt_sel_e'(wdata[7:5]);
    assign act    = decode_action(wdata[4:0]);
    assign act_wr = ctl_wr && (sel == SEL_ACTION);

    assign ptr_clr    = act_wr && act.ptr_rst;
    assign latch_xfer = act_wr && (act.xfr == XFR_TO_LATCH);
    assign psc_load   = act_wr && (act.xfr == XFR_TO_PSC);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            io_q   <= '0;
            idx_q  <= '0;
        end else if (ctl_wr) begin
            case (sel)
                SEL_MODE:  mode_q <= mode_cfg_t'(wdata[4:1]);
                SEL_IOCTL: io_q   <= io_cfg_t'({wdata[4:3], wdata[1:0]});
                SEL_INDEX: idx_q  <= idx_cfg_t'(wdata[1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_preset <= 1'b0;
            clear_count <= 1'b0;
            clear_flags <= 1'b0;
            clear_error <= 1'b0;
        end else begin
            load_preset <= act_wr && (act.xfr == XFR_TO_COUNT);
            clear_count <= act_wr && (act.clr == CLR_COUNT);
            clear_flags <= act_wr && (act.clr == CLR_FLAGS);
            clear_error <= act_wr && (act.clr == CLR_ERROR);
        end
    end

    // R9
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_preset |-> $past(ctl_wr && wdata[7:5] == 3'b000 && wdata[4:3] == 2'b01));

    // R5
    ignore_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[7]) |=> ($stable({mode_q, io_q, idx_q}) &&
            !load_preset && !clear_count && !clear_flags && !clear_error));

endmodule

// File: rtl/cnt_host_regs.sv
module cnt_host_regs
    import cnt_host_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic                        bus_sel_ctl,
    input  logic [BYTE_W-1:0]           bus_wdata,
    output logic [BYTE_W-1:0]           bus_rdata,
    input  logic [BYTE_W*NUM_BYTES-1:0] cnt_value,
    input  logic                        flag_borrow,
    input  logic                        flag_carry,
    input  logic                        flag_noise,
    input  logic                        flag_up,
    output logic [BYTE_W*NUM_BYTES-1:0] preset_val,
    output logic                        load_preset,
    output logic                        clear_count,
    output logic                        clear_flags,
    output logic                        clear_error,
    output logic [1:0]                  count_mode,
    output logic [1:0]                  quad_mode,
    output logic                        ab_enable,
    output logic                        index_load_n,
    output logic [1:0]                  irq_src,
    output logic                        index_sync,
    output logic                        index_positive,
    output logic [BYTE_W-1:0]           prescaler
);
    localparam int PTR_W = $clog2(NUM_BYTES);

    logic [PTR_W-1:0]  ptr;
    logic              data_acc;
    logic              ptr_clr;
    logic              latch_xfer;
    logic              psc_load;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] psc_q;
    mode_cfg_t         mode_q;
    io_cfg_t           io_q;
    idx_cfg_t          idx_q;
    flag_in_t          flags;

    assign data_acc = (bus_wr || bus_rd) && !bus_sel_ctl;

    cnt_byte_ptr #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) ptr_i (
        .clk     (clk),
        .rst     (rst),
        .advance (data_acc),
        .clear   (ptr_clr),
        .ptr     (ptr)
    );

    cnt_preset_latch #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) pl_i (
        .clk        (clk),
        .rst        (rst),
        .ptr        (ptr),
        .data_wr    (bus_wr && !bus_sel_ctl),
        .wdata      (bus_wdata),
        .latch_xfer (latch_xfer),
        .cnt_value  (cnt_value),
        .preset_q   (preset_val),
        .rd_byte    (rd_byte)
    );

    cnt_cmd_decode dec_i (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (bus_wr && bus_sel_ctl),
        .wdata       (bus_wdata[7:0]),
        .mode_q      (mode_q),
        .io_q        (io_q),
        .idx_q       (idx_q),
        .ptr_clr     (ptr_clr),
        .latch_xfer  (latch_xfer),
        .psc_load    (psc_load),
        .load_preset (load_preset),
        .clear_count (clear_count),
        .clear_flags (clear_flags),
        .clear_error (clear_error)
    );

    always_ff @(posedge clk) begin
        if (rst)
            psc_q <= '0;
        else if (psc_load)
            psc_q <= preset_val[BYTE_W-1:0];
    end

    assign flags     = '{up: flag_up, noise: flag_noise, carry: flag_carry, borrow: flag_borrow};
    assign bus_rdata = bus_sel_ctl ? BYTE_W'(pack_flags(flags)) : rd_byte;

    assign count_mode     = mode_q.count_mode;
    assign quad_mode      = mode_q.quad_mode;
    assign ab_enable      = io_q.ab_en;
    assign index_load_n   = io_q.index_load_n;
    assign irq_src        = io_q.irq_src;
    assign index_sync     = idx_q.index_sync;
    assign index_positive = idx_q.index_pos;
    assign prescaler      = psc_q;

    // R10
    psc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !psc_load |=> $stable(prescaler));

endmodule

// File: tb/cnt_host_regs_tb.sv
module cnt_host_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_ctl = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] cnt_value = '0;
    logic        flag_borrow = 0, flag_carry = 0, flag_noise = 0, flag_up = 0;
    logic [23:0] preset_val;
    logic        load_preset, clear_count, clear_flags, clear_error;
    logic [1:0]  count_mode, quad_mode, irq_src;
    logic        ab_enable, index_load_n, index_sync, index_positive;
    logic [7:0]  prescaler;

    int checks = 0;
    int errors = 0;

    // bench model
    int          mptr = 0;
    logic [23:0] mpreset = '0, mlatch = '0;
    logic [7:0]  mpsc = '0;
    logic [1:0]  mcm = '0, mqm = '0, mirq = '0;
    logic        mab = 0, midxn = 0, msync = 0, mpos = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cnt_host_regs dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel_ctl(bus_sel_ctl), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_value(cnt_value), .flag_borrow(flag_borrow), .flag_carry(flag_carry),
        .flag_noise(flag_noise), .flag_up(flag_up), .preset_val(preset_val),
        .load_preset(load_preset), .clear_count(clear_count),
        .clear_flags(clear_flags), .clear_error(clear_error),
        .count_mode(count_mode), .quad_mode(quad_mode), .ab_enable(ab_enable),
        .index_load_n(index_load_n), .irq_src(irq_src), .index_sync(index_sync),
        .index_positive(index_positive), .prescaler(prescaler)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] cfg_dut();
        return 64'({preset_val, prescaler, count_mode, quad_mode, ab_enable,
                    index_load_n, irq_src, index_sync, index_positive});
    endfunction

    function automatic logic [63:0] cfg_model();
        return 64'({mpreset, mpsc, mcm, mqm, mab, midxn, mirq, msync, mpos});
    endfunction

    function automatic logic [63:0] strobes_dut();
        return 64'({load_preset, clear_count, clear_flags, clear_error});
    endfunction

    task automatic ctl_wr(input logic [7:0] b);
        @(negedge clk);
        bus_sel_ctl = 1'b1; bus_wr = 1'b1; bus_wdata = b;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic dat_wr(input logic [7:0] b);
        @(negedge clk);
        bus_sel_ctl = 1'b0; bus_wr = 1'b1; bus_wdata = b;
        @(negedge clk);
        bus_wr = 1'b0;
        mpreset[8*mptr +: 8] = b;
        mptr = (mptr + 1) % 3;
    endtask

    task automatic dat_rd(input string req);
        @(negedge clk);
        bus_sel_ctl = 1'b0; bus_rd = 1'b1;
        #1;
        check(req, 64'(bus_rdata), 64'(mlatch[8*mptr +: 8]));
        @(negedge clk);
        bus_rd = 1'b0;
        mptr = (mptr + 1) % 3;
    endtask

    // apply a control byte to the model, returning expected strobes
    function automatic logic [3:0] model_ctl(input logic [7:0] b);
        logic [3:0] s = '0;
        case (b[7:5])
            3'b000: begin
                s = {b[4:3] == 2'b01, b[2:1] == 2'b01, b[2:1] == 2'b10, b[2:1] == 2'b11};
                if (b[0]) mptr = 0;
                if (b[4:3] == 2'b10) mlatch = cnt_value;
                if (b[4:3] == 2'b11) mpsc = mpreset[7:0];
            end
            3'b001: begin mcm = b[2:1]; mqm = b[4:3]; end
            3'b010: begin mab = b[0]; midxn = b[1]; mirq = b[4:3]; end
            3'b011: begin msync = b[0]; mpos = b[1]; end
            default: ;
        endcase
        return s;
    endfunction

    function automatic string tag_of(input logic [7:0] b);
        case (b[7:5])
            3'b000:  return (b[4:3] == 2'b11) ? "R10" : "R8";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [3:0] es;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", cfg_dut(), 64'd0);
        check("R1", strobes_dut(), 64'd0);
        bus_sel_ctl = 1'b0; #1;
        check("R1", 64'(bus_rdata), 64'd0);

        // R6 preset fill, LSB first, then wrap
        dat_wr(8'hC3); dat_wr(8'hB2); dat_wr(8'hA1);
        check("R6", 64'(preset_val), 64'hA1B2C3);
        dat_wr(8'h5E);
        check("R6", 64'(preset_val), 64'hA1B25E);
        ctl_wr(8'h01); void'(model_ctl(8'h01));
        dat_wr(8'hC3);
        check("R6", 64'(preset_val), 64'hA1B2C3);

        // R7 snapshot: pointer reset combined with transfer to latch
        cnt_value = 24'h123456;
        ctl_wr(8'h11); void'(model_ctl(8'h11));
        cnt_value = 24'hFEDCBA;
        dat_rd("R7"); dat_rd("R7"); dat_rd("R7"); dat_rd("R7");
        check("R7", 64'(mlatch), 64'h123456);

        // sweep of all control bytes
        for (int b = 0; b < 256; b++) begin
            cnt_value = {b[7:0], ~b[7:0], b[7:0] ^ 8'h5A};
            ctl_wr(b[7:0]);
            es = model_ctl(b[7:0]);
            check(tag_of(b[7:0]), cfg_dut(), cfg_model());
            check("R9", strobes_dut(), 64'(es));
            @(negedge clk);
            check("R9", strobes_dut(), 64'd0);
            if (b % 16 == 15) begin
                dat_rd("R7"); dat_rd("R8");
            end
        end

        // R11 flag byte sweep, pointer must not move
        for (int f = 0; f < 16; f++) begin
            @(negedge clk);
            {flag_up, flag_noise, flag_carry, flag_borrow} = f[3:0];
            bus_sel_ctl = 1'b1; bus_rd = 1'b1;
            #1;
            check("R11", 64'(bus_rdata), 64'({2'b00, f[3], f[2], 2'b00, f[1], f[0]}));
            @(negedge clk);
            bus_rd = 1'b0;
        end
        dat_rd("R11"); dat_rd("R11");

        // R10 prescaler from fresh preset low byte
        ctl_wr(8'h01); void'(model_ctl(8'h01));
        dat_wr(8'h3C); dat_wr(8'h00); dat_wr(8'h00);
        ctl_wr(8'h18); void'(model_ctl(8'h18));
        check("R10", 64'(prescaler), 64'h3C);
        dat_wr(8'h99);
        check("R10", 64'(prescaler), 64'h3C);

        // R1 reset again restores zero state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", 64'({preset_val, prescaler, count_mode, quad_mode, irq_src}), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule